// File: doc/BRIEF.md
# Redundant Clock Failover Selector

This block sits in front of a clock tree that has two candidate source clocks. A faster free-running reference clock samples both sources all the time. Each source has its own activity monitor. That monitor counts the reference cycles since the source last changed level. If the source holds one level for longer than a programmable count, the monitor latches a bad flag for it. The count is set to one nominal source period plus margin, so a source stuck low and a source stuck high are both caught within about one period.

The selection controller keeps one source as the current one and passes it to `clk_out` through a gated multiplexer. When the current source is flagged bad and the other source is not, the controller hands over automatically. The old source's gate is closed first, on that source's falling edge, or immediately if the source is dead. Only after that closure has been seen does the controller open the new source's gate, on the new source's falling edge.

A preference input picks the source used after reset. A manual override input makes that preference the only thing that decides the selection. An active-low init input clears latched flags, but only for a source that is toggling again.

Top module: `clk_failover`

## Requirements
- R1: While `rst` is high, and right after it is released, `active_src` equals `pref_sel` and `src_bad` is 2'b00. Bit 0 of every two-bit vector belongs to source 0 and bit 1 to source 1.
- R2: Both sources are watched whether or not they are in use. A source that stays low, or stays high, for more than `stuck_limit` reference cycles gets its `src_bad` bit set.
- R3: A `src_bad` bit stays set while `init_n` is high. It clears only while `init_n` is low and its source is toggling again. A source that is still stuck keeps its flag even with `init_n` low.
- R4: With `man_ovr` low, if the current source is flagged bad and the other source is not, the selection moves to the other source.
- R5: With `man_ovr` low, a recovered source is not reselected, and a change of `pref_sel` does not move the selection.
- R6: With `man_ovr` low and both flags set, the selection stays where it is.
- R7: With `man_ovr` high, the selection follows `pref_sel` whatever the flags say, and automatic failover is blocked.
- R8: `active_src` (0 = source 0, 1 = source 1) changes only once the new source's gate is open. `clk_out` then toggles at the active source's frequency, or stays still if that source is stuck.
- R9: At no time are both source gates open together, and `clk_out` never shows a high or low pulse shorter than the shorter half period of the sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, faster than both sources |
| rst | input | 1 | Synchronous active-high reset in the reference domain |
| src_clk | input | 2 | The two candidate source clocks (bit 0 = source 0) |
| init_n | input | 1 | Active-low clear request for the latched bad flags |
| pref_sel | input | 1 | Preferred source after reset; sole selector when overridden |
| man_ovr | input | 1 | High disables automatic failover |
| stuck_limit | input | CNT_W | Reference cycles without a level change before a source is bad |
| clk_out | output | 1 | Gated, selected source clock |
| src_bad | output | 2 | Latched per-source bad flags |
| active_src | output | 1 | Source currently driving `clk_out` |

## Verification
The case that matters is a flag clear and a failover decision landing on the same cycle. In one vector, source 1's flag is cleared by an init pulse while source 0, the current source, is still stuck. The clear is the very event that makes the alternate eligible, so the handover must start from it. Two things judge the outcome: the flag pattern, where the stuck source must keep its flag, and the indicator together with the rising-edge count of `clk_out` over a fixed window. The override vectors provoke the opposite collision: a current source fails while `man_ovr` is high, and the bench checks that no handover happens and that `clk_out` goes quiet.

// File: rtl/clk_fo_pkg.sv
package clk_fo_pkg;
  localparam int NSRC = 2;

  typedef enum logic [1:0] {
    SW_RUN   = 2'd0,
    SW_DROP  = 2'd1,
    SW_RAISE = 2'd2
  } sw_state_e;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/clk_act_mon.sv
// Per-source activity monitor in the reference domain.
module clk_act_mon #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_clk,
  input  logic             init_n,
  input  logic [CNT_W-1:0] limit,
  output logic             bad
);
  localparam int              SH_W    = SYNC_STAGES + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] quiet;
  logic             toggled;
  logic             stuck_now;

  // synchronizer plus one history stage for level-change detection
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SH_W-2:0], src_clk};
  end

  assign toggled = sh[SH_W-1] ^ sh[SH_W-2];

  // cycles since last level change, saturating
  always_ff @(posedge clk) begin
    if (rst)                  quiet <= '0;
    else if (toggled)         quiet <= '0;
    else if (quiet != CNT_TOP) quiet <= quiet + 1'b1;
  end

  assign stuck_now = (quiet > limit);

  // latched flag; a clear is honoured only while the source is alive
  always_ff @(posedge clk) begin
    if (rst)            bad <= 1'b0;
    else if (stuck_now) bad <= 1'b1;
    else if (!init_n)   bad <= 1'b0;
  end
endmodule

// File: rtl/clk_gate_cell.sv
// Clock gate whose enable moves only on the source's falling edge.
module clk_gate_cell #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic clr,
  input  logic req,
  output logic en,
  output logic gclk
);
  logic [STAGES-1:0] s;

  always_ff @(negedge src_clk or posedge clr) begin
    if (clr) s <= '0;
    else     s <= {s[STAGES-2:0], req};
  end

  assign en   = s[STAGES-1];
  assign gclk = src_clk & en;
endmodule

// File: rtl/clk_sw_ctrl.sv
// Selection controller: break-before-make handover in the reference domain.
module clk_sw_ctrl
  import clk_fo_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pref_sel,
  input  logic            man_ovr,
  input  logic [NSRC-1:0] bad,
  input  logic [NSRC-1:0] ack,
  output logic [NSRC-1:0] req,
  output logic [NSRC-1:0] kill,
  output logic            active
);
  sw_state_e state;
  logic      cur;
  logic      tgt;
  logic      want;

  always_comb begin
    want = cur;
    if (man_ovr)                      want = pref_sel;
    else if (bad[cur] && !bad[~cur])  want = ~cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= SW_RUN;
      cur           <= pref_sel;
      tgt           <= pref_sel;
      req           <= '0;
      req[pref_sel] <= 1'b1;
      kill          <= '1;
    end else begin
      // a released gate on a dead source cannot see a falling edge: clear it
      kill <= ~req & bad;
      case (state)
        SW_RUN: begin
          if (want != cur) begin
            req[cur] <= 1'b0;
            tgt      <= want;
            state    <= SW_DROP;
          end
        end
        SW_DROP: begin
          if (!ack[cur]) begin
            req[tgt] <= 1'b1;
            state    <= SW_RAISE;
          end
        end
        SW_RAISE: begin
          if (ack[tgt]) begin
            cur   <= tgt;
            state <= SW_RUN;
          end
        end
        default: state <= SW_RUN;
      endcase
    end
  end

  assign active = cur;
endmodule

// File: rtl/clk_failover.sv
module clk_failover
  import clk_fo_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int GATE_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_clk,
  input  logic             init_n,
  input  logic             pref_sel,
  input  logic             man_ovr,
  input  logic [CNT_W-1:0] stuck_limit,
  output logic             clk_out,
  output logic [NSRC-1:0]  src_bad,
  output logic             active_src
);
  logic [NSRC-1:0] gate_en;
  logic [NSRC-1:0] gclk;
  logic [NSRC-1:0] ack;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] kill;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      clk_act_mon #(
        .CNT_W      (CNT_W),
        .SYNC_STAGES(SYNC_STAGES)
      ) u_mon (
        .clk    (clk),
        .rst    (rst),
        .src_clk(src_clk[g]),
        .init_n (init_n),
        .limit  (stuck_limit),
        .bad    (src_bad[g])
      );

      clk_gate_cell #(
        .STAGES(GATE_STAGES)
      ) u_gate (
        .src_clk(src_clk[g]),
        .clr    (kill[g]),
        .req    (req[g]),
        .en     (gate_en[g]),
        .gclk   (gclk[g])
      );
    end
  endgenerate

  bit_sync #(
    .W     (NSRC),
    .STAGES(SYNC_STAGES)
  ) u_ack (
    .clk(clk),
    .rst(rst),
    .d  (gate_en),
    .q  (ack)
  );

  clk_sw_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .pref_sel(pref_sel),
    .man_ovr (man_ovr),
    .bad     (src_bad),
    .ack     (ack),
    .req     (req),
    .kill    (kill),
    .active  (active_src)
  );

  assign clk_out = |gclk;
endmodule

// File: rtl/clk_failover_chk.sv
module clk_failover_chk
  import clk_fo_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            init_n,
  input logic            pref_sel,
  input logic [NSRC-1:0] src_bad,
  input logic            active_src,
  input logic [NSRC-1:0] gate_en
);
  AST_RESET_PREF: assert property (@(posedge clk) rst |=> (active_src == $past(pref_sel)) && (src_bad == '0)); // R1

  AST_FLAG0_HOLD: assert property (@(posedge clk) disable iff (rst) (src_bad[0] && init_n) |=> src_bad[0]); // R3

  AST_FLAG1_HOLD: assert property (@(posedge clk) disable iff (rst) (src_bad[1] && init_n) |=> src_bad[1]); // R3

  AST_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst) ($fell(src_bad[0]) || $fell(src_bad[1])) |-> !$past(init_n)); // R3

  AST_IND_AFTER_OPEN: assert property (@(posedge clk) disable iff (rst) !$stable(active_src) |-> gate_en[active_src]); // R8

  AST_ONE_GATE: assert property (@(posedge clk) disable iff (rst) $countones(gate_en) <= 1); // R9
endmodule

bind clk_failover clk_failover_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .init_n    (init_n),
  .pref_sel  (pref_sel),
  .src_bad   (src_bad),
  .active_src(active_src),
  .gate_en   (gate_en)
);

// File: tb/tb_clk_failover.sv
`timescale 1ns/1ps
module tb_clk_failover;
  localparam int CNT_W = 8;
  localparam int HALF0 = 20;  // source 0: 40 ns period
  localparam int HALF1 = 28;  // source 1: 56 ns period
  localparam int NVEC  = 15;

  // {mode0[1:0], mode1[1:0], ovr, pref, init, bad[1:0], act}; mode 0 run, 1 stuck low, 2 stuck high
  localparam logic [9:0] VEC [NVEC] = '{
    10'b00_00_0_0_0_00_0,
    10'b01_00_0_0_0_01_1,
    10'b00_00_0_0_0_01_1,
    10'b00_00_0_0_1_00_1,
    10'b00_10_0_0_0_10_0,
    10'b01_10_0_0_0_11_0,
    10'b01_00_0_0_1_01_1,
    10'b00_00_0_0_1_00_1,
    10'b00_00_1_0_0_00_0,
    10'b00_10_1_0_0_10_0,
    10'b01_00_1_0_1_01_0,
    10'b01_00_0_0_0_01_1,
    10'b00_00_0_0_1_00_1,
    10'b00_00_1_1_0_00_1,
    10'b00_00_0_0_0_00_1
  };

  logic clk = 1'b0;
  logic rst, init_n, pref_sel, man_ovr;
  logic c0 = 1'b0, c1 = 1'b0;
  logic [1:0] m0 = 2'd0, m1 = 2'd0;
  logic clk_out, active_src;
  logic [1:0] src_bad;

  int n_chk = 0, n_bad = 0, edges = 0, runts = 0;
  bit cnt_en = 0, armed = 0, done = 0;
  time t_r = 0, t_f = 0;

  always #2 clk = ~clk;
  always begin #HALF0; if (m0 == 2'd0) c0 = ~c0; else c0 = (m0 == 2'd2); end
  always begin #HALF1; if (m1 == 2'd0) c1 = ~c1; else c1 = (m1 == 2'd2); end

  clk_failover #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .src_clk({c1, c0}), .init_n(init_n),
    .pref_sel(pref_sel), .man_ovr(man_ovr), .stuck_limit(8'd20),
    .clk_out(clk_out), .src_bad(src_bad), .active_src(active_src)
  );

  always @(posedge clk_out) begin
    if (cnt_en) edges++;
    if (armed && t_f != 0 && ($time - t_f) < 19) runts++;
    t_r = $time;
  end
  always @(negedge clk_out) begin
    if (armed && t_r != 0 && ($time - t_r) < 19) runts++;
    t_f = $time;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_near(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act < exp - 1 || act > exp + 1) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic count_edges();
    edges = 0; cnt_en = 1; #560; cnt_en = 0;
    @(negedge clk);
  endtask

  function automatic string row_tag(input int i);
    case (i)
      0: return "R8";  1: return "R4";  2: return "R5";  3: return "R3";
      4: return "R2";  5: return "R6";  6: return "R3";  7: return "R3";
      8: return "R7";  9: return "R2";  10: return "R7"; 11: return "R4";
      12: return "R3"; 13: return "R7"; default: return "R5";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1; init_n = 1; pref_sel = 0; man_ovr = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    chk("R1", "indicator after reset", active_src, 0);
    chk("R1", "flags after reset", src_bad, 0);
    repeat (100) @(negedge clk);
    armed = 1;

    for (int i = 0; i < NVEC; i++) begin
      logic [9:0] v;
      int em, ee;
      v = VEC[i];
      m0 = v[9:8]; m1 = v[7:6]; man_ovr = v[5]; pref_sel = v[4];
      repeat (100) @(negedge clk);
      if (v[3]) begin
        init_n = 0; repeat (4) @(negedge clk); init_n = 1;
      end
      repeat (150) @(negedge clk);
      count_edges();
      em = v[0] ? int'(m1) : int'(m0);
      ee = (em != 0) ? 0 : (v[0] ? 10 : 14);
      chk(row_tag(i), $sformatf("row %0d flags", i), src_bad, int'(v[2:1]));
      chk(row_tag(i), $sformatf("row %0d indicator", i), active_src, int'(v[0]));
      chk_near("R8", $sformatf("row %0d clk_out edges", i), edges, ee);
    end

    // unused source 0 still watched (R2)
    m0 = 2'd1;
    repeat (150) @(negedge clk);
    chk("R2", "idle source flagged", src_bad, 1);
    chk("R2", "no move on idle fault", active_src, 1);

    // init held low while stuck, then recovery during init (R3)
    init_n = 0;
    repeat (200) @(negedge clk);
    chk("R3", "stuck source keeps flag under init", src_bad, 1);
    m0 = 2'd0;
    repeat (100) @(negedge clk);
    chk("R3", "flag clears once toggling", src_bad, 0);
    init_n = 1;

    // reset with preference on source 1 (R1)
    armed = 0;
    pref_sel = 1; m0 = 2'd1;
    repeat (100) @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    chk("R1", "indicator after reset pref 1", active_src, 1);
    chk("R1", "flags cleared by reset", src_bad, 0);
    m0 = 2'd0;
    repeat (200) @(negedge clk);
    count_edges();
    chk_near("R8", "clk_out follows source 1", edges, 10);

    chk("R9", "short pulses on clk_out", runts, 0);
    finish_run();
  end
endmodule